// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a simple host request port and a 4M x 16 extended-data-out DRAM. The host presents a 22-bit word address, 16-bit write data, two byte enables and a read/write flag. The block splits the address into a 12-bit row and a 10-bit column. It places each half in turn on a shared 12-bit address bus and drives the active-low row strobe, the two byte-lane column strobes, the write enable and the output enable. Reads come back on a response port as a single-cycle valid pulse.

After an access the row stays open. A later request to the same row is served in page mode: only the column strobes cycle, with a new column address. The page closes on a row miss, on a refresh, or after an idle timeout. In each case the row strobe rises and stays high for the precharge time. A refresh timer raises a pending request at the interval needed to spread 4096 refreshes over 64 ms. The controller serves it as a column-before-row refresh, and it takes priority over new host requests. Every timing limit is given in nanoseconds. It is turned into clock cycles as ceil(ns / clock period), with a minimum of one cycle.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the host holds the request steady. `req_ready` is high only in two cases: the controller is idle with the page closed, or the page is open and the request's row matches it. In both cases no refresh may be pending. There is no back-pressure on the response port.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is asserted, `dram_ras_n`, `dram_casl_n`, `dram_cash_n`, `dram_we_n` and `dram_oe_n` are 1, and `rsp_valid` and `dram_dq_oe` are 0. After reset `req_ready` is 1.
- R2: For a normal access, `dram_addr` equals `req_addr[21:10]` when the row strobe falls. It equals `{2'b00, req_addr[9:0]}` when a column strobe falls.
- R3: Each accepted read produces exactly one `rsp_valid` pulse, one cycle wide, in request order. `rsp_data` holds the latest data written to that word; a word never written reads as 0.
- R4: `req_be[0]` selects bits 7:0 through `dram_casl_n`, and `req_be[1]` selects bits 15:8 through `dram_cash_n`. Only the enabled lanes' column strobes fall, so a write leaves the other byte unchanged.
- R5: Back-to-back requests to the row already open are served without the row strobe falling again.
- R6: An open page closes on a row miss, on a refresh, or after `IDLE_CYC` idle cycles. After the row strobe rises it stays high for at least the precharge cycle count before it falls again.
- R7: The row strobe stays low for at least the active-time cycle count. Successive row-strobe falls are at least the random-cycle count apart. A read's column strobe rises at least the access-time cycle count after the row strobe fell.
- R8: A refresh lowers both column strobes at least one cycle before the row strobe falls, with `dram_we_n` at 1. At least one refresh is issued per refresh interval.
- R9: A pending refresh is served after the access in progress. It takes priority over new host requests, including open-page hits, so a stream of hits cannot delay it by more than a short bounded time.
- R10: `req_ready` is 0 whenever a column strobe is low, that is, during any access or refresh.
- R11: During an access, `dram_we_n` is 0 only for writes and `dram_oe_n` is 0 only for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: row in 21:10, column in 9:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_data | output | 16 | Read data |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Low-byte column strobe, active low |
| dram_cash_n | output | 1 | High-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | 16 | Data returned from the DRAM |

## Verification
Some faults in the open-row register or the sequencer state show up within one access. A stale row register makes a page hit go to the wrong row, so the next read returns the wrong word. A sequencer that leaves a strobe in the wrong level breaks a strobe-width or ordering check at the next row-strobe edge. A fault in the refresh timer or the refresh priority can stay hidden for one refresh interval. It shows up as a gap between refresh cycles larger than the interval plus the service latency. To expose it, a long stream of open-page hits is driven so that the page is never closed for any other reason.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RCD, S_COL, S_CAS, S_OPEN, S_PRE, S_RCAS, S_RRAS
  } seq_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
  parameter int REFI_CYC = 782
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_pend
);
  localparam int CW = (REFI_CYC < 2) ? 1 : $clog2(REFI_CYC);
  localparam logic [CW-1:0] LAST = CW'(REFI_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ref_pend <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)         ref_pend <= 1'b1;
      else if (ref_ack) ref_pend <= 1'b0;
    end
  end

  // R9: a pending refresh is never dropped before it is served
  a_r9_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend && !ref_ack |=> ref_pend);
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 10,
  parameter int DATA_W   = 16,
  parameter int RCD_CYC  = 2,
  parameter int CAS_CYC  = 1,
  parameter int RAS_CYC  = 3,
  parameter int RP_CYC   = 2,
  parameter int IDLE_CYC = 16,
  localparam int ADDR_W  = ROW_W + COL_W,
  localparam int AW      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              ref_pend,
  output logic              ref_ack,
  output logic [AW-1:0]     dram_addr,
  output logic              dram_ras_n,
  output logic              dram_casl_n,
  output logic              dram_cash_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int CW = $clog2(IDLE_CYC + RCD_CYC + CAS_CYC + RAS_CYC + RP_CYC + 1);
  localparam logic [CW-1:0] RCD_L  = CW'(RCD_CYC - 1);
  localparam logic [CW-1:0] CAS_L  = CW'(CAS_CYC - 1);
  localparam logic [CW-1:0] RAS_L  = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] RP_L   = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] IDLE_L = CW'(IDLE_CYC - 1);
  localparam int GW = $clog2(RAS_CYC + 1);
  localparam logic [GW-1:0] AGE_MAX = GW'(RAS_CYC);

  seq_t             state_q;
  logic [CW-1:0]    cnt_q;
  logic [GW-1:0]    age_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [1:0]       be_q;
  logic             row_match, accept, close_req;

  assign row_match = (req_addr[ADDR_W-1:COL_W] == row_q);
  assign req_ready = !ref_pend && ((state_q == S_IDLE) || (state_q == S_OPEN && row_match));
  assign accept    = req_valid && req_ready;
  assign ref_ack   = (state_q == S_IDLE) && ref_pend;
  assign close_req = ref_pend || (req_valid && !row_match) || (cnt_q >= IDLE_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      age_q       <= '0;
      row_q       <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      be_q        <= 2'b00;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_casl_n <= 1'b1;
      dram_cash_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (!dram_ras_n && age_q != AGE_MAX) age_q <= age_q + 1'b1;
      case (state_q)
        S_IDLE: begin
          if (ref_pend) begin
            dram_casl_n <= 1'b0;
            dram_cash_n <= 1'b0;
            state_q     <= S_RCAS;
          end else if (accept) begin
            row_q       <= req_addr[ADDR_W-1:COL_W];
            col_q       <= req_addr[COL_W-1:0];
            wr_q        <= req_write;
            be_q        <= req_be;
            dram_dq_out <= req_wdata;
            dram_addr   <= AW'(req_addr[ADDR_W-1:COL_W]);
            dram_ras_n  <= 1'b0;
            age_q       <= GW'(1);
            cnt_q       <= RCD_L;
            state_q     <= S_RCD;
          end
        end
        S_RCD: begin
          if (cnt_q == '0) begin
            dram_addr  <= AW'(col_q);
            dram_we_n  <= !wr_q;
            dram_oe_n  <= wr_q;
            dram_dq_oe <= wr_q;
            state_q    <= S_COL;
          end else cnt_q <= cnt_q - 1'b1;
        end
        S_COL: begin
          dram_casl_n <= !be_q[0];
          dram_cash_n <= !be_q[1];
          cnt_q       <= CAS_L;
          state_q     <= S_CAS;
        end
        S_CAS: begin
          if (cnt_q == '0) begin
            dram_casl_n <= 1'b1;
            dram_cash_n <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_dq_oe  <= 1'b0;
            if (!wr_q) begin
              rsp_valid <= 1'b1;
              rsp_data  <= dram_dq_in;
            end
            cnt_q   <= '0;
            state_q <= S_OPEN;
          end else cnt_q <= cnt_q - 1'b1;
        end
        S_OPEN: begin
          if (accept) begin
            col_q       <= req_addr[COL_W-1:0];
            wr_q        <= req_write;
            be_q        <= req_be;
            dram_dq_out <= req_wdata;
            dram_addr   <= AW'(req_addr[COL_W-1:0]);
            dram_we_n   <= !req_write;
            dram_oe_n   <= req_write;
            dram_dq_oe  <= req_write;
            state_q     <= S_COL;
          end else if (close_req) begin
            if (age_q == AGE_MAX) begin
              dram_ras_n <= 1'b1;
              cnt_q      <= RP_L;
              state_q    <= S_PRE;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_PRE: begin
          if (cnt_q == '0) state_q <= S_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        S_RCAS: begin
          dram_ras_n <= 1'b0;
          age_q      <= GW'(1);
          cnt_q      <= RAS_L;
          state_q    <= S_RRAS;
        end
        S_RRAS: begin
          if (cnt_q == '0) begin
            dram_ras_n  <= 1'b1;
            dram_casl_n <= 1'b1;
            dram_cash_n <= 1'b1;
            cnt_q       <= RP_L;
            state_q     <= S_PRE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R8: column strobes lead the row strobe in refresh, write disabled
  a_r8_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) && !dram_casl_n |-> $past(!dram_casl_n) && $past(!dram_cash_n) && dram_we_n);
  // R10: no acceptance while a column strobe is active
  a_r10_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> dram_casl_n && dram_cash_n);
  // R3: read response is a single-cycle pulse
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R4: a low-lane write strobe only with the low byte enabled
  a_r4_lane_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_casl_n) && !dram_ras_n && !dram_we_n |-> be_q[0]);
  // R7: row strobe only rises after the active time has elapsed
  a_r7_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> $past(age_q) == AGE_MAX);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 20,
  parameter int T_RAS_NS  = 50,
  parameter int T_RP_NS   = 30,
  parameter int T_RCD_NS  = 37,
  parameter int T_CAS_NS  = 13,
  parameter int T_REFI_NS = 15625,
  parameter int IDLE_CYC  = 16,
  localparam int ADDR_W   = ROW_W + COL_W,
  localparam int AW       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [AW-1:0]     dram_addr,
  output logic              dram_ras_n,
  output logic              dram_casl_n,
  output logic              dram_cash_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int RAS_CYC  = ns_to_cyc(T_RAS_NS, CLK_NS);
  localparam int RP_CYC   = ns_to_cyc(T_RP_NS, CLK_NS);
  localparam int RCD_CYC  = ns_to_cyc(T_RCD_NS, CLK_NS);
  localparam int CAS_CYC  = ns_to_cyc(T_CAS_NS, CLK_NS);
  localparam int REFI_CYC = ns_to_cyc(T_REFI_NS, CLK_NS);

  logic ref_pend, ref_ack;

  edo_ref_timer #(.REFI_CYC(REFI_CYC)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_pend(ref_pend)
  );

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .RCD_CYC(RCD_CYC), .CAS_CYC(CAS_CYC), .RAS_CYC(RAS_CYC),
    .RP_CYC(RP_CYC), .IDLE_CYC(IDLE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ref_pend(ref_pend), .ref_ack(ref_ack),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_casl_n(dram_casl_n), .dram_cash_n(dram_cash_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );
endmodule

// File: tb/edo_page_ctrl_test.sv
module edo_page_ctrl_test;
  localparam int REFI_NS  = 4000;
  localparam int RAS_CYC  = 3;    // ceil(50/20)
  localparam int RP_CYC   = 2;    // ceil(30/20)
  localparam int RC_CYC   = 5;    // ceil(84/20)
  localparam int RAC_CYC  = 3;    // ceil(50/20)
  localparam int REFI_CYC = 200;  // ceil(4000/20)
  localparam int IDLE_CYC = 16;
  localparam int SLACK    = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, rsp_valid;
  logic [21:0] req_addr;
  logic [15:0] req_wdata, rsp_data, dram_dq_out, dram_dq_in;
  logic [1:0]  req_be;
  logic [11:0] dram_addr;
  logic dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dram_dq_oe;

  edo_page_ctrl #(.T_REFI_NS(REFI_NS), .IDLE_CYC(IDLE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n), .dram_cash_n(dram_cash_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] be);
    return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
  endfunction

  // reference model: expected memory, expected responses, last accepted request
  logic [15:0] sb [int];
  logic [15:0] stub [int];
  logic [15:0] expq [$];
  logic        acc_wr = 1'b0;
  logic [21:0] acc_addr = '0;
  logic [1:0]  acc_be = 2'b11;

  // monitor state
  int cyc = 0, ras_edge = 0, last_fall = -1, last_ref = 0, ref_cnt = 0, acc_falls = 0;
  logic p_ras = 1'b1, p_casl = 1'b1, p_cash = 1'b1, p_rv = 1'b0;
  logic [11:0] st_row = '0;
  logic [15:0] stub_rd = '0;
  assign dram_dq_in = stub_rd;

  always @(negedge clk) if (rst_n && !done) begin
    cyc++;
    if (p_ras && !dram_ras_n) begin
      chk(cyc - ras_edge >= RP_CYC, "R6 precharge width", cyc - ras_edge, RP_CYC);
      if (last_fall >= 0) chk(cyc - last_fall >= RC_CYC, "R7 row cycle time", cyc - last_fall, RC_CYC);
      last_fall = cyc;
      ras_edge  = cyc;
      if (!dram_casl_n || !dram_cash_n) begin
        chk(!p_casl && !p_cash && !dram_casl_n && !dram_cash_n && dram_we_n, "R8 refresh order",
            {p_casl, p_cash, dram_casl_n, dram_cash_n, dram_we_n}, 5'b00001);
        chk(cyc - last_ref <= REFI_CYC + SLACK, "R9 refresh gap", cyc - last_ref, REFI_CYC + SLACK);
        last_ref = cyc;
        ref_cnt++;
      end else begin
        chk(dram_addr == acc_addr[21:10], "R2 row address", dram_addr, acc_addr[21:10]);
        st_row = dram_addr;
        acc_falls++;
      end
    end
    if (!p_ras && dram_ras_n) begin
      chk(cyc - ras_edge >= RAS_CYC, "R7 row strobe low width", cyc - ras_edge, RAS_CYC);
      ras_edge = cyc;
    end
    if (!dram_ras_n && ((p_casl && !dram_casl_n) || (p_cash && !dram_cash_n))) begin
      int key;
      key = int'({st_row, acc_addr[9:0]});
      chk(dram_addr == {2'b00, acc_addr[9:0]}, "R2 column address", dram_addr, {2'b00, acc_addr[9:0]});
      chk({!dram_cash_n, !dram_casl_n} == acc_be, "R4 lane strobes", {!dram_cash_n, !dram_casl_n}, acc_be);
      chk(dram_we_n == !acc_wr && dram_oe_n == acc_wr, "R11 write/output enable",
          {dram_we_n, dram_oe_n}, {!acc_wr, acc_wr});
      if (!dram_we_n) begin
        chk(dram_dq_oe, "R11 data drive", dram_dq_oe, 1);
        stub[key] = merge(stub.exists(key) ? stub[key] : 16'h0, dram_dq_out, {!dram_cash_n, !dram_casl_n});
      end else begin
        stub_rd = stub.exists(key) ? stub[key] : 16'h0;
      end
    end
    if (!dram_ras_n && (!p_casl || !p_cash) && dram_casl_n && dram_cash_n && !acc_wr)
      chk(cyc - last_fall >= RAC_CYC, "R7 access time", cyc - last_fall, RAC_CYC);
    if (req_ready && (!dram_casl_n || !dram_cash_n))
      chk(1'b0, "R10 ready while busy", req_ready, 0);
    if (rsp_valid) begin
      chk(!p_rv, "R3 single-cycle pulse", p_rv, 0);
      if (expq.size() == 0) chk(1'b0, "R3 unexpected response", rsp_data, 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(rsp_data == e, "R3 read data", rsp_data, e);
      end
    end
    p_ras  = dram_ras_n;
    p_casl = dram_casl_n;
    p_cash = dram_cash_n;
    p_rv   = rsp_valid;
  end

  task automatic req(input bit wr, input logic [21:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    acc_wr = wr; acc_addr = a; acc_be = be;
    if (wr) sb[int'(a)] = merge(sb.exists(int'(a)) ? sb[int'(a)] : 16'h0, d, be);
    else expq.push_back(sb.exists(int'(a)) ? sb[int'(a)] : 16'h0);
    #1 req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = 2'b11;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n} == 5'b11111, "R1 strobes idle",
        {dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n}, 5'b11111);
    chk(!rsp_valid && !dram_dq_oe, "R1 outputs quiet", {rsp_valid, dram_dq_oe}, 0);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // R2/R3: full-word writes across rows, then read back
    for (int i = 0; i < 8; i++)
      req(1'b1, 22'((i * 37) << 10) | 22'(i * 5 + 3), 16'(16'h1000 + i * 16'h1111), 2'b11);
    for (int i = 0; i < 8; i++)
      req(1'b0, 22'((i * 37) << 10) | 22'(i * 5 + 3), 16'h0, 2'b11);
    req(1'b0, 22'h3FFFFF, 16'h0, 2'b11);  // never written: R3 reads 0

    // R4: byte-lane writes keep the other byte
    req(1'b1, 22'h12345, 16'h1234, 2'b11);
    req(1'b1, 22'h12345, 16'hAAAA, 2'b01);
    req(1'b0, 22'h12345, 16'h0, 2'b11);
    req(1'b1, 22'h12345, 16'h5500, 2'b10);
    req(1'b0, 22'h12345, 16'h0, 2'b11);

    // R5: page hits right after a refresh open the row only once
    begin
      int r0, f0;
      r0 = ref_cnt;
      while (ref_cnt == r0) @(negedge clk);
      f0 = acc_falls;
      for (int i = 0; i < 8; i++)
        req(i[0] ? 1'b0 : 1'b1, 22'((5 << 10) | (i[0] ? i - 1 : i)), 16'(16'hC000 + i), 2'b11);
      chk(acc_falls - f0 == 1, "R5 page hits share one row open", acc_falls - f0, 1);
    end

    // R6: idle timeout closes the page (unless a refresh holds both CAS low)
    repeat (IDLE_CYC + 10) @(negedge clk);
    #1 chk(dram_ras_n || !dram_casl_n, "R6 idle close", dram_ras_n, 1);

    // R6: row misses alternate rows
    for (int i = 0; i < 10; i++) begin
      req(1'b1, 22'(((i % 2) + 1) << 10) | 22'(i), 16'(16'h7700 + i), 2'b11);
      req(1'b0, 22'(((i % 2) + 1) << 10) | 22'(i), 16'h0, 2'b11);
    end

    // R9: a long stream of page hits must not hold off refresh
    for (int i = 0; i < 400; i++)
      req(1'b0, 22'((7 << 10) | (i % 64)), 16'h0, 2'b11);

    repeat (30) @(negedge clk);
    chk(expq.size() == 0, "R3 every read answered", expq.size(), 0);
    chk(ref_cnt >= cyc / REFI_CYC - 1, "R8 refresh budget", ref_cnt, cyc / REFI_CYC - 1);
    finish_run();
  end
endmodule